// File: doc/BRIEF.md
# Bus Target Claim Unit

This block is the target-side front end of a shared parallel bus. It watches the framing and initiator-ready strobes. When a new transaction begins it latches the address and the command presented on that edge. It then decides whether this target owns the cycle, and claims it by pulling its device-select output low. All bus strobes are active low.

Two claim policies are available, chosen by a static mode input. In positive-decode mode the latched address is compared against a programmable base/mask window and the command against an acceptance bitmap. The claim then lands one, two or three clocks after the address edge, a setting that trades decode time for latency. In subtractive mode the window is not used. The unit listens to the device-select of every other target and claims, one clock after the slowest positive decoder could have, only when nobody else has answered. A claim is held until the bus goes idle. Target-ready and stop stay deasserted throughout, because data phases belong to other logic.

Top module: `tgt_claim_unit`

## Requirements
- R1: A transaction start is an edge where `frame_n` is sampled low after an edge where `frame_n` and `irdy_n` were both high. On that edge `cap_addr` and `cap_cmd` load `ad_in` and `cbe_in`, and they hold those values until the next start. Reset clears both to zero.
- R2: With `claim_mode` = 2'b00 (fast) and a hit, `devsel_n` is low after the start edge itself. Seen from the bus it is sampled low on the first edge after the start.
- R3: With `claim_mode` = 2'b01 (medium) and a hit, `devsel_n` goes low after the first edge following the start.
- R4: With `claim_mode` = 2'b10 (slow) and a hit, `devsel_n` goes low after the second edge following the start.
- R5: With `claim_mode` = 2'b11 (subtractive), an accepted command and `other_claim_n` sampled high on edges 1, 2 and 3 after the start, `devsel_n` goes low after the third edge following the start. The window does not matter. A low `other_claim_n` on any later edge does not cancel the claim.
- R6: In subtractive mode, if `other_claim_n` is sampled low on any of edges 1 to 3 after the start, `devsel_n` stays high for that whole transaction.
- R7: In the positive modes a hit requires two things. The first is `((addr ^ win_base) & win_mask) == 0`, where a mask bit of 1 means that address bit is compared. The second is that bit `cmd` of `cmd_accept` is set. A miss leaves `devsel_n` high for the whole transaction. Subtractive mode also requires the command bit.
- R8: Once low, `devsel_n` stays low until an edge samples `frame_n` and `irdy_n` both high. It is high right after that edge.
- R9: `trdy_n` and `stop_n` are always high.
- R10: In the three positive modes `other_claim_n` has no effect on `devsel_n`.
- R11: After reset, a transaction already in progress (`frame_n` low without a preceding idle edge) is never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Framing strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| ad_in | input | ADDR_W | Address bus |
| cbe_in | input | CMD_W | Command code during the address edge |
| other_claim_n | input | 1 | Device-select as driven by the other targets, active low |
| claim_mode | input | 2 | 00 fast, 01 medium, 10 slow, 11 subtractive; static |
| win_base | input | ADDR_W | Window base address |
| win_mask | input | ADDR_W | Window compare mask, 1 = bit compared |
| cmd_accept | input | 2**CMD_W | Bit n set = command n may be claimed |
| devsel_n | output | 1 | Claim output, active low |
| trdy_n | output | 1 | Target-ready, held high |
| stop_n | output | 1 | Stop, held high |
| cap_addr | output | ADDR_W | Address latched at the last start |
| cap_cmd | output | CMD_W | Command latched at the last start |

## Verification
The claim state machine lives in a handful of flops. A wrong count or a wrong mode decode shows up as `devsel_n` falling one or more edges early or late, within four edges of the start. A wrong subtractive memory of other claims shows up as a claim where a competing target already answered, or as a missing claim, by the fourth edge. A claim state that is not cleared is seen as `devsel_n` staying low on the first edge after the bus goes idle. A start that is not recognised is seen as a missing or stale `cap_addr` on the start edge itself.

// File: rtl/tgt_claim_pkg.sv
package tgt_claim_pkg;

    typedef enum logic [1:0] {
        MODE_FAST   = 2'b00,
        MODE_MEDIUM = 2'b01,
        MODE_SLOW   = 2'b10,
        MODE_SUBTR  = 2'b11
    } claim_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIMED,
        ST_SKIP
    } claim_state_e;

    localparam int EDGE_W = 3;

    typedef struct packed {
        claim_state_e        state;
        logic [EDGE_W-1:0]   edge_no;   // index of the next edge after the start
        logic                seen;      // another target answered
        logic                devsel_n;
    } claim_regs_t;

    // Edge after the start (start edge = 1) whose update drives the claim low.
    function automatic logic [EDGE_W-1:0] claim_edge(claim_mode_e m);
        case (m)
            MODE_FAST:   return EDGE_W'(1);
            MODE_MEDIUM: return EDGE_W'(2);
            MODE_SLOW:   return EDGE_W'(3);
            default:     return EDGE_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/tgt_bus_watch.sv
module tgt_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic idle_now,
    output logic start_now
);
    logic idle_seen_d, idle_seen_q;

    always_comb begin
        idle_now    = frame_n & irdy_n;
        start_now   = idle_seen_q & ~frame_n;
        idle_seen_d = idle_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_seen_q <= 1'b0;
        else        idle_seen_q <= idle_seen_d;
    end
endmodule

// File: rtl/tgt_addr_latch.sv
module tgt_addr_latch #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic [CMD_W-1:0]  cbe_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CMD_W-1:0]  cmd_q
);
    logic [ADDR_W-1:0] addr_d;
    logic [CMD_W-1:0]  cmd_d;

    always_comb begin
        addr_d = addr_q;
        cmd_d  = cmd_q;
        if (load) begin
            addr_d = ad_in;
            cmd_d  = cbe_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
        end else begin
            addr_q <= addr_d;
            cmd_q  <= cmd_d;
        end
    end
endmodule

// File: rtl/tgt_window_match.sv
module tgt_window_match #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    localparam int NCMD  = 1 << CMD_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [NCMD-1:0]   accept,
    output logic              in_window,
    output logic              cmd_ok
);
    logic [ADDR_W-1:0] diff;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign diff[i] = (addr[i] ^ base[i]) & mask[i];
    end

    always_comb begin
        in_window = ~|diff;
        cmd_ok    = accept[cmd];
    end
endmodule

// File: rtl/tgt_claim_unit.sv
module tgt_claim_unit
    import tgt_claim_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    localparam int NCMD  = 1 << CMD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic [CMD_W-1:0]  cbe_in,
    input  logic              other_claim_n,
    input  logic [1:0]        claim_mode,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic [NCMD-1:0]   cmd_accept,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CMD_W-1:0]  cap_cmd
);
    logic idle_now, start_now;
    logic in_window, cmd_ok;
    claim_regs_t r_d, r_q;
    claim_mode_e mode;
    logic [EDGE_W-1:0] target_edge;
    logic subtr, hit_live, seen_now;

    tgt_bus_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .idle_now (idle_now),
        .start_now(start_now)
    );

    tgt_addr_latch #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_now && r_q.state == ST_IDLE),
        .ad_in (ad_in),
        .cbe_in(cbe_in),
        .addr_q(cap_addr),
        .cmd_q (cap_cmd)
    );

    // Decode runs on the live bus so that a fast claim can leave on the start edge.
    tgt_window_match #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_match (
        .addr     (ad_in),
        .cmd      (cbe_in),
        .base     (win_base),
        .mask     (win_mask),
        .accept   (cmd_accept),
        .in_window(in_window),
        .cmd_ok   (cmd_ok)
    );

    always_comb begin
        mode        = claim_mode_e'(claim_mode);
        target_edge = claim_edge(mode);
        subtr       = (mode == MODE_SUBTR);
        hit_live    = subtr ? cmd_ok : (in_window & cmd_ok);
        seen_now    = r_q.seen | (subtr & ~other_claim_n);
        r_d         = r_q;

        case (r_q.state)
            ST_IDLE: begin
                r_d.devsel_n = 1'b1;
                r_d.seen     = 1'b0;
                if (start_now) begin
                    if (!hit_live) begin
                        r_d.state = ST_SKIP;
                    end else if (target_edge == EDGE_W'(1)) begin
                        r_d.state    = ST_CLAIMED;
                        r_d.devsel_n = 1'b0;
                    end else begin
                        r_d.state   = ST_DECODE;
                        r_d.edge_no = EDGE_W'(2);
                    end
                end
            end
            ST_DECODE: begin
                r_d.seen = seen_now;
                if (idle_now) begin
                    r_d.state = ST_IDLE;
                end else if (seen_now) begin
                    r_d.state = ST_SKIP;
                end else if (r_q.edge_no == target_edge) begin
                    r_d.state    = ST_CLAIMED;
                    r_d.devsel_n = 1'b0;
                end else begin
                    r_d.edge_no = r_q.edge_no + EDGE_W'(1);
                end
            end
            ST_CLAIMED: begin
                if (idle_now) begin
                    r_d.state    = ST_IDLE;
                    r_d.devsel_n = 1'b1;
                end
            end
            default: begin
                if (idle_now) r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.edge_no  <= '0;
            r_q.seen     <= 1'b0;
            r_q.devsel_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        devsel_n = r_q.devsel_n;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
    end
endmodule

// File: rtl/tgt_claim_checker.sv
module tgt_claim_checker #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    localparam int NCMD  = 1 << CMD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              other_claim_n,
    input logic [1:0]        claim_mode,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_mask,
    input logic [NCMD-1:0]   cmd_accept,
    input logic              devsel_n,
    input logic              trdy_n,
    input logic              stop_n,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [CMD_W-1:0]  cap_cmd
);
    a_r9_trdy_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_n && stop_n);

    a_r2_fast_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_mode == 2'b00) |->
            (!$past(frame_n) && $past(frame_n, 2) && $past(irdy_n, 2)));

    a_r3_medium_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_mode == 2'b01) |->
            (!$past(frame_n, 2) && $past(frame_n, 3) && $past(irdy_n, 3)));

    a_r4_slow_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_mode == 2'b10) |->
            (!$past(frame_n, 3) && $past(frame_n, 4) && $past(irdy_n, 4)));

    a_r5_subtr_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_mode == 2'b11) |->
            (!$past(frame_n, 4) && $past(frame_n, 5) && $past(irdy_n, 5)));

    a_r6_subtr_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_mode == 2'b11) |->
            ($past(other_claim_n) && $past(other_claim_n, 2) && $past(other_claim_n, 3)));

    a_r7_claim_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && claim_mode != 2'b11) |->
            ((((cap_addr ^ win_base) & win_mask) == '0) && cmd_accept[cap_cmd]));

    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && !(frame_n && irdy_n)) |=> !devsel_n);

    a_r8_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && irdy_n) |=> devsel_n);
endmodule

bind tgt_claim_unit tgt_claim_checker #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .other_claim_n(other_claim_n),
    .claim_mode   (claim_mode),
    .win_base     (win_base),
    .win_mask     (win_mask),
    .cmd_accept   (cmd_accept),
    .devsel_n     (devsel_n),
    .trdy_n       (trdy_n),
    .stop_n       (stop_n),
    .cap_addr     (cap_addr),
    .cap_cmd      (cap_cmd)
);

// File: tb/tgt_claim_unit_tb.sv
module tgt_claim_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam logic [31:0] BASE   = 32'h4000_0000;
    localparam logic [31:0] MASK   = 32'hFFF0_0000;
    localparam logic [15:0] ACCEPT = 16'hD0C0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, other_claim_n = 1'b1;
    logic [ADDR_W-1:0] ad_in = '0;
    logic [CMD_W-1:0]  cbe_in = '0;
    logic [1:0] claim_mode = 2'b00;
    logic [ADDR_W-1:0] win_base = BASE, win_mask = MASK;
    logic [15:0] cmd_accept = ACCEPT;
    logic devsel_n, trdy_n, stop_n;
    logic [ADDR_W-1:0] cap_addr;
    logic [CMD_W-1:0]  cap_cmd;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tgt_claim_unit #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_in(cbe_in), .other_claim_n(other_claim_n),
        .claim_mode(claim_mode), .win_base(win_base), .win_mask(win_mask),
        .cmd_accept(cmd_accept), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .cap_addr(cap_addr), .cap_cmd(cap_cmd)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int claim_at(logic [1:0] m);
        return int'(m) + 1;
    endfunction

    function automatic bit expect_claim(logic [1:0] m, logic [31:0] a, logic [3:0] c, int oth);
        bit ok = ACCEPT[c];
        if (m == 2'b11) return ok && !(oth >= 2 && oth <= 4);
        return ok && (((a ^ BASE) & MASK) == 32'h0);
    endfunction

    function automatic string tag_for(logic [1:0] m, bit cl, int oth);
        if (m == 2'b11) return cl ? "R5" : "R6";
        if (!cl) return "R7";
        if (oth != 0) return "R10";
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic go_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b1; other_claim_n = 1'b1;
            ad_in = $urandom; cbe_in = $urandom;
        end
    endtask

    // Transaction: frame low on edges 1..L-1, irdy low on edges 2..L,
    // other target low from edge oth to L (oth = 0: never). Idle seen at edge L+1.
    task automatic run_txn(logic [1:0] m, logic [31:0] a, logic [3:0] c, int oth, int len);
        bit cl;
        int te;
        string tg;
        claim_mode = m;
        go_idle(2);
        cl = expect_claim(m, a, c, oth);
        te = claim_at(m);
        tg = tag_for(m, cl, oth);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_in = c;
        other_claim_n = 1'b1;
        for (int e = 1; e <= len + 1; e++) begin
            @(negedge clk);
            if (e == 1 || e == len) begin
                check("R1 cap_addr", cap_addr, a);
                check("R1 cap_cmd", {28'h0, cap_cmd}, {28'h0, c});
            end
            if (e == len + 1) check("R8 release", {31'h0, devsel_n}, 32'h1);
            else check(tg, {31'h0, devsel_n}, {31'h0, !(cl && e >= te)});
            check("R9 trdy/stop", {30'h0, trdy_n, stop_n}, 32'h3);
            frame_n = (e + 1 <= len - 1) ? 1'b0 : 1'b1;
            irdy_n  = (e + 1 >= 2 && e + 1 <= len) ? 1'b0 : 1'b1;
            other_claim_n = (oth != 0 && e + 1 >= oth && e + 1 <= len) ? 1'b0 : 1'b1;
            ad_in = $urandom; cbe_in = $urandom;
        end
        go_idle(1);
    endtask

    function automatic logic [31:0] pick_addr();
        if ($urandom_range(1, 0) == 1) return BASE | ($urandom & ~MASK);
        return $urandom;
    endfunction

    function automatic logic [3:0] pick_cmd();
        logic [3:0] good [4] = '{4'd6, 4'd7, 4'd12, 4'd14};
        if ($urandom_range(2, 0) != 0) return good[$urandom_range(3, 0)];
        return 4'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // Reset state, with a transaction already running (R11 setup).
        frame_n = 1'b0; irdy_n = 1'b0; ad_in = BASE; cbe_in = 4'd6;
        repeat (3) @(negedge clk);
        check("R1 reset cap_addr", cap_addr, 32'h0);
        check("R8 reset devsel", {31'h0, devsel_n}, 32'h1);
        check("R9 reset trdy/stop", {30'h0, trdy_n, stop_n}, 32'h3);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 3) frame_n = 1'b1;
            check("R11 no claim mid-transaction", {31'h0, devsel_n}, 32'h1);
        end
        go_idle(2);

        // Directed window edges, every mode.
        for (int m = 0; m < 3; m++) begin
            run_txn(2'(m), BASE, 4'd7, 0, 5);
            run_txn(2'(m), BASE | ~MASK, 4'd6, 0, 6);
            run_txn(2'(m), BASE - 1, 4'd6, 0, 5);
            run_txn(2'(m), (BASE | ~MASK) + 1, 4'd6, 0, 5);
            run_txn(2'(m), BASE, 4'd0, 0, 5);
            run_txn(2'(m), BASE, 4'd7, 2, 6);
        end
        // Subtractive timing corners.
        run_txn(2'b11, 32'h1234_5678, 4'd6, 0, 5);
        run_txn(2'b11, 32'h1234_5678, 4'd6, 2, 6);
        run_txn(2'b11, 32'h1234_5678, 4'd6, 4, 6);
        run_txn(2'b11, 32'h1234_5678, 4'd6, 5, 7);
        run_txn(2'b11, BASE, 4'd1, 0, 5);

        // Random traffic.
        for (int n = 0; n < 400; n++) begin
            logic [1:0] m = 2'($urandom);
            int oth;
            int othv [5] = '{0, 2, 3, 4, 5};
            if (m == 2'b11) oth = othv[$urandom_range(4, 0)];
            else oth = ($urandom_range(1, 0) == 1) ? $urandom_range(6, 2) : 0;
            run_txn(m, pick_addr(), pick_cmd(), oth, $urandom_range(8, 5));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule